// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers up to 31 hardware event lines into a cause register and gates them with an enable mask to drive a single level-sensitive interrupt line. Bit 31 of the cause word is a read-only summary bit. It is high whenever a pending cause bit meets a set mask bit, and the interrupt output follows it. Software reaches the block over a small register bus with a 3-bit address, a write strobe, a read strobe, write data and combinational read data.

Software can remove cause bits in three ways. It can write ones to the cause address to clear those bits. It can read the cause register, and under the rules below that read clears it. It can mark bits as self-clearing, so that each such bit stays set only in the cycle after its event. Reading the cause register can also drop enables, using an auto-mask register. A parameter selects the read rule. In strict mode every cause read clears the register. In conditional mode the clear depends on the mask and the summary bit.

Register addresses:

| Address | Read | Write |
|---|---|---|
| 0 | cause word (may clear) | write 1 to clear |
| 1 | 0 | set cause bits |
| 2 | mask | OR into mask |
| 3 | 0 | clear mask bits |
| 4 | auto-mask | auto-mask |
| 5 | self-clear select | self-clear select |

Addresses 6 and 7 read 0.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause, mask, auto-mask and self-clear registers are zero and irq is 0.
- R2: Read bit 31 of the cause word equals the OR of (cause & mask) over bits 30:0, and irq equals that bit in the same cycle.
- R3: A write to address 2 ORs the data into the mask. A write to address 3 clears the mask bits where the data is 1. A read of address 2 returns the mask in bits 30:0 with bit 31 zero.
- R4: A write to address 0 clears each cause bit whose data bit is 1 and leaves the other bits unchanged.
- R5: A write to address 1 sets the cause bits where the data is 1. These bits feed bit 31 and irq exactly as hardware events do.
- R6: In conditional mode, a read of address 0 while the mask is zero returns the cause word and then clears the cause register.
- R7: A read of address 0 while bit 31 is 1 and the auto-mask register is nonzero clears the cause register and removes the auto-mask bits from the mask.
- R8: A read of address 0 while bit 31 is 1 and the auto-mask register is zero clears the cause register and leaves the mask unchanged.
- R9: In conditional mode, a read of address 0 while bit 31 is 0 and the mask is nonzero changes no register.
- R10: In strict mode (STRICT_READ=1), every read of address 0 clears the cause register. The auto-mask rule of R7 still applies.
- R11: An event or cause-set bit arriving in the same cycle as any clear of that bit is set in the cause register after the edge.
- R12: A cause bit whose self-clear select bit (address 5) is 1 is cleared at every edge that has no new event or set for it.
- R13: Read data is valid in the same cycle as the read strobe. It shows the value before that read's side effects. When the read strobe is low, read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ev_in | input | 31 | hardware event pulses, one per cause bit |
| bus_addr | input | 3 | register address |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe (side effects act when bus_wr is low) |
| bus_wdata | input | 31 | write data |
| bus_rdata | output | 32 | read data |
| irq | output | 1 | level interrupt output |

## Verification
The hardest situation to reach is a cause read that hits an asserted, auto-masked register in the same cycle as a new event. Here the clear, the mask removal and the event capture all land on one edge. Directed steps build that state in stages: set the mask and auto-mask, raise a cause bit through the set register, then issue the read together with an event pulse. A long seeded random phase then mixes writes, reads and sparse events. Both read modes run side by side on the same stimulus, each compared with its own bench model.

// File: rtl/icm_pkg.sv
package icm_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NREG   = 6;

  localparam logic [ADDR_W-1:0] ADR_CAUSE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CSET  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MSET  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MCLR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_AMASK = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_ACLR  = 3'd5;

  typedef struct packed {
    logic clr_all;   // wipe cause register
    logic apply_am;  // drop auto-mask bits from mask
  } rd_act_t;

  // Read side-effect rule shared by both modes.
  function automatic rd_act_t read_action(input logic strict, input logic mask_zero,
                                          input logic asserted, input logic am_active);
    rd_act_t a;
    a.clr_all  = strict | mask_zero | asserted;
    a.apply_am = asserted & am_active;
    return a;
  endfunction
endpackage

// File: rtl/icm_bus_decode.sv
module icm_bus_decode
  import icm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [NREG-1:0]   wr_hit,
  output logic              rd_cause
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = wr_en && (addr == ADDR_W'(i));
  end
  // A read carries side effects only when no write shares the cycle.
  assign rd_cause = rd_en && !wr_en && (addr == ADR_CAUSE);
endmodule

// File: rtl/icm_mask_bank.sv
module icm_mask_bank #(
  parameter int unsigned SRC_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mset,
  input  logic             wr_mclr,
  input  logic             wr_am,
  input  logic             wr_ac,
  input  logic [SRC_W-1:0] wd,
  input  logic             am_apply,
  output logic [SRC_W-1:0] mask_q,
  output logic [SRC_W-1:0] am_q,
  output logic [SRC_W-1:0] ac_q
);
  function automatic logic [SRC_W-1:0] next_mask(
      input logic [SRC_W-1:0] m, input logic s, input logic c, input logic a,
      input logic [SRC_W-1:0] d, input logic [SRC_W-1:0] am);
    logic [SRC_W-1:0] r;
    r = m;
    if (s) r = r | d;
    if (c) r = r & ~d;
    if (a) r = r & ~am;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      am_q   <= '0;
      ac_q   <= '0;
    end else begin
      mask_q <= next_mask(mask_q, wr_mset, wr_mclr, am_apply, wd, am_q);
      if (wr_am) am_q <= wd;
      if (wr_ac) ac_q <= wd;
    end
  end

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask_q & $past(wd)) == $past(wd)));
  assert_automask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    am_apply |=> ((mask_q & $past(am_q)) == '0));
endmodule

// File: rtl/icm_cause_bank.sv
module icm_cause_bank #(
  parameter int unsigned SRC_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_w1c,
  input  logic             wr_set,
  input  logic [SRC_W-1:0] wd,
  input  logic             clr_all,
  input  logic [SRC_W-1:0] ac_q,
  input  logic [SRC_W-1:0] ev_in,
  input  logic [SRC_W-1:0] mask_q,
  output logic [SRC_W-1:0] cause_q,
  output logic             asserted
);
  function automatic logic [SRC_W-1:0] next_cause(
      input logic [SRC_W-1:0] c, input logic w1c, input logic set, input logic clr,
      input logic [SRC_W-1:0] d, input logic [SRC_W-1:0] ac, input logic [SRC_W-1:0] ev);
    logic [SRC_W-1:0] r;
    r = c;
    if (w1c) r = r & ~d;
    if (clr) r = '0;
    r = r & ~ac;
    r = r | ev | (set ? d : '0);   // new bits land after every clear
    return r;
  endfunction

  assign asserted = |(cause_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= next_cause(cause_q, wr_w1c, wr_set, clr_all, wd, ac_q, ev_in);
  end

  assert_event_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in != '0) |=> ((cause_q & $past(ev_in)) == $past(ev_in)));
  assert_clear_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !wr_set) |=> ((cause_q & ~$past(ev_in)) == '0));
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import icm_pkg::*;
#(
  parameter int unsigned SRC_W       = 31,
  parameter bit          STRICT_READ = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_W-1:0]     ev_in,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [SRC_W-1:0]     bus_wdata,
  output logic [SRC_W:0]       bus_rdata,
  output logic                 irq
);
  localparam int unsigned DW = SRC_W + 1;

  logic [NREG-1:0]  wr_hit;
  logic             rd_cause;
  logic [SRC_W-1:0] mask_q, am_q, ac_q, cause_q;
  logic             asserted;
  rd_act_t          act;
  logic             clr_all, am_apply;

  icm_bus_decode u_dec (
    .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
    .wr_hit(wr_hit), .rd_cause(rd_cause)
  );

  assign act      = read_action(STRICT_READ, (mask_q == '0), asserted, (am_q != '0));
  assign clr_all  = rd_cause && act.clr_all;
  assign am_apply = rd_cause && act.apply_am;

  icm_mask_bank #(.SRC_W(SRC_W)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .wr_mset(wr_hit[ADR_MSET]), .wr_mclr(wr_hit[ADR_MCLR]),
    .wr_am(wr_hit[ADR_AMASK]), .wr_ac(wr_hit[ADR_ACLR]),
    .wd(bus_wdata), .am_apply(am_apply),
    .mask_q(mask_q), .am_q(am_q), .ac_q(ac_q)
  );

  icm_cause_bank #(.SRC_W(SRC_W)) u_cause (
    .clk(clk), .rst_n(rst_n),
    .wr_w1c(wr_hit[ADR_CAUSE]), .wr_set(wr_hit[ADR_CSET]),
    .wd(bus_wdata), .clr_all(clr_all), .ac_q(ac_q),
    .ev_in(ev_in), .mask_q(mask_q),
    .cause_q(cause_q), .asserted(asserted)
  );

  assign irq = asserted;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADR_CAUSE: bus_rdata = {asserted, cause_q};
        ADR_MSET:  bus_rdata = {1'b0, mask_q};
        ADR_AMASK: bus_rdata = {1'b0, am_q};
        ADR_ACLR:  bus_rdata = {1'b0, ac_q};
        default:   bus_rdata = DW'(0);
      endcase
    end
  end

  assert_irq_needs_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));
  assert_quiet_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!STRICT_READ && rd_cause && !irq && (mask_q != '0) && (ev_in == '0) && (ac_q == '0))
      |=> ($stable(cause_q) && $stable(mask_q)));
endmodule

// File: tb/tb_irq_cause_ctrl.sv
`timescale 1ns/1ps
module tb_irq_cause_ctrl;
  localparam int SRC_W = 31;
  logic clk = 0, rst_n = 0;
  logic [SRC_W-1:0] ev_in = '0, bus_wdata = '0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [SRC_W:0] rd_c, rd_s;
  logic irq_c, irq_s;
  int n_tot = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_cause_ctrl #(.SRC_W(SRC_W), .STRICT_READ(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rd_c), .irq(irq_c));
  irq_cause_ctrl #(.SRC_W(SRC_W), .STRICT_READ(1'b1)) dut_strict (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rd_s), .irq(irq_s));

  // Bench model: index 0 conditional mode, index 1 strict mode.
  logic [SRC_W-1:0] m_cause [2], m_mask [2], m_am [2], m_ac [2];

  function automatic logic m_hot(input int k);
    return |(m_cause[k] & m_mask[k]);
  endfunction

  function automatic logic [31:0] m_read(input int k, input logic [2:0] a);
    case (a)
      3'd0: return {m_hot(k), m_cause[k]};
      3'd2: return {1'b0, m_mask[k]};
      3'd4: return {1'b0, m_am[k]};
      3'd5: return {1'b0, m_ac[k]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge(input logic wr, input logic rd, input logic [2:0] a,
                            input logic [SRC_W-1:0] d, input logic [SRC_W-1:0] ev);
    for (int k = 0; k < 2; k++) begin
      logic hot, cl, ap;
      logic [SRC_W-1:0] c, m;
      hot = m_hot(k);
      cl  = rd && !wr && a == 3'd0 && (k == 1 || m_mask[k] == '0 || hot);
      ap  = rd && !wr && a == 3'd0 && hot && m_am[k] != '0;
      m = m_mask[k];
      if (wr && a == 3'd2) m = m | d;
      if (wr && a == 3'd3) m = m & ~d;
      if (ap) m = m & ~m_am[k];
      c = m_cause[k];
      if (wr && a == 3'd0) c = c & ~d;
      if (cl) c = '0;
      c = c & ~m_ac[k];
      c = c | ev | ((wr && a == 3'd1) ? d : '0);
      if (wr && a == 3'd4) m_am[k] = d;
      if (wr && a == 3'd5) m_ac[k] = d;
      m_mask[k]  = m;
      m_cause[k] = c;
    end
  endtask

  // One bus cycle: drive at the falling edge, check before the rising edge.
  task automatic step(input logic wr, input logic rd, input logic [2:0] a,
                      input logic [SRC_W-1:0] d, input logic [SRC_W-1:0] ev, input string req);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; ev_in = ev;
    #2;
    chk({req, " irq cond"},   {31'd0, irq_c}, {31'd0, m_hot(0)});
    chk({req, " irq strict"}, {31'd0, irq_s}, {31'd0, m_hot(1)});
    if (rd) begin
      chk({req, " rdata cond"},   rd_c, m_read(0, a));
      chk({req, " rdata strict"}, rd_s, m_read(1, a));
    end else begin
      chk({req, " idle rdata"}, rd_c | rd_s, 32'd0);
    end
    @(posedge clk);
    model_edge(wr, rd, a, d, ev);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [SRC_W-1:0] d, input string req);
    step(1'b1, 1'b0, a, d, '0, req);
  endtask
  task automatic rd_reg(input logic [2:0] a, input string req);
    step(1'b0, 1'b1, a, '0, '0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tot++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_cause[k] = '0; m_mask[k] = '0; m_am[k] = '0; m_ac[k] = '0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq_c | irq_s}, 32'd0);
    rd_reg(3'd0, "R1 cause"); rd_reg(3'd2, "R1 mask");
    rd_reg(3'd4, "R1 automask"); rd_reg(3'd5, "R1 selfclear");

    // R6 mask zero: read clears (conditional); R13 pre-clear value
    step(1'b0, 1'b0, 3'd0, '0, 31'h5, "R11 event");
    rd_reg(3'd0, "R6 R13 first read");
    rd_reg(3'd0, "R6 after clear");

    // R3 mask set / clear
    wr_reg(3'd2, 31'h0F, "R3 set");
    rd_reg(3'd2, "R3 read mask");
    wr_reg(3'd3, 31'h03, "R3 clr");
    rd_reg(3'd2, "R3 read mask after clr");

    // R9 not asserted, mask nonzero: no change; R10 strict clears
    wr_reg(3'd1, 31'h10, "R5 set unmasked");
    rd_reg(3'd0, "R9 quiet read");
    rd_reg(3'd0, "R9 R10 second read");

    // R5 R2 asserted via set; R8 read clears, mask kept
    wr_reg(3'd1, 31'h04, "R5 set masked");
    rd_reg(3'd0, "R2 R8 asserted read");
    rd_reg(3'd2, "R8 mask kept");
    rd_reg(3'd0, "R8 cleared");

    // R7 auto-mask
    wr_reg(3'd4, 31'h04, "R7 am write");
    wr_reg(3'd1, 31'h04, "R7 raise");
    rd_reg(3'd0, "R7 read");
    rd_reg(3'd2, "R7 mask after");

    // R4 write one to clear
    wr_reg(3'd1, 31'h30, "R4 raise");
    wr_reg(3'd0, 31'h10, "R4 w1c");
    rd_reg(3'd0, "R4 read");

    // R11 event during clearing read with auto-mask active
    wr_reg(3'd2, 31'h04, "R11 remask");
    wr_reg(3'd1, 31'h04, "R11 raise");
    step(1'b0, 1'b1, 3'd0, '0, 31'h02, "R11 R7 collide read");
    rd_reg(3'd0, "R11 survivor");
    rd_reg(3'd2, "R11 mask after");

    // R12 self-clear
    wr_reg(3'd4, 31'h0, "R12 am off");
    wr_reg(3'd2, 31'h01, "R12 mask");
    wr_reg(3'd0, 31'h7FFFFFFF, "R12 wipe");
    wr_reg(3'd5, 31'h40, "R12 select");
    step(1'b0, 1'b0, 3'd0, '0, 31'h40, "R12 event");
    rd_reg(3'd0, "R12 visible");
    rd_reg(3'd0, "R12 gone");

    // Random phase
    for (int i = 0; i < 1500; i++) begin
      int unsigned op;
      logic [SRC_W-1:0] d, ev;
      op = $urandom % 9;
      d  = SRC_W'($urandom);
      ev = ($urandom % 5 == 0) ? (SRC_W'($urandom) & SRC_W'($urandom) & SRC_W'($urandom)) : '0;
      if (op == 1) d = d & SRC_W'($urandom);
      if (op == 5) d = d & 31'h0F0;
      if (op == 4) d = ($urandom % 2 == 0) ? '0 : (d & 31'h0FF);
      if (op <= 5) step(1'b1, 1'b0, 3'(op), d, ev, "R2 R13 random write");
      else         step(1'b0, 1'b1, 3'($urandom % 8), '0, ev, "R2 R13 random read");
    end

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule